// File: doc/BRIEF.md
# Qualified Trace Capture Buffer

This block records a window of probe samples into an on-chip circular memory around a single trigger event. After an arm pulse it stores samples continuously, wrapping the write address, until a trigger arrives. It then stores a programmed number of further samples and stops with a done flag raised. The address written on the trigger cycle is latched, so software or a downstream engine can read the buffer back in time order through a simple synchronous read port.

The probe bus is split into equal-width groups. Each group has a compile-time probe enable and a compile-time storage enable. Only groups with both enables set are packed into the stored word. An optional qualifier input restricts writes to the cycles where it is high. A one-cycle trigger-out pulse lets the trigger event be routed to other logic or off chip.

Top module: `trace_capture`

## Requirements
- R1: `DEPTH` must be a power of two from 512 to 131072 (default 1024), and any other value stops elaboration. The write address wraps from `DEPTH-1` back to 0.
- R2: The stored word holds only the groups whose bits are set in both `PROBE_EN` and `STORE_EN`. They are packed from bit 0 upward in rising group order. If this gives a stored width of zero, elaboration stops.
- R3: An arm pulse does the following at the next edge: the block enters the armed state, triggered and done are cleared, and the write address returns to 0. Nothing is written on the arm cycle, and a trigger on that same cycle is ignored.
- R4: While armed, every qualified cycle writes the packed probe word at the write address, and the address then increments.
- R5: With `QUAL_EN`=1, only cycles with `qual_i` high are written. With `QUAL_EN`=0, every capture cycle is written.
- R6: A trigger is accepted only in the armed state. On acceptance, `trig_addr_o` takes the write address of that cycle, armed falls and triggered rises.
- R7: From the trigger cycle onward, exactly min(`post_len_i`, `DEPTH`) qualified samples are written, and then done rises. The trigger cycle's own sample counts if it is qualified. With `post_len_i`=0, done rises at once and the trigger cycle is not written.
- R8: `trig_out_o` is high for exactly one cycle, in the cycle after an accepted trigger.
- R9: A trigger in the idle, post-trigger or done state has no effect on the flags, `trig_addr_o`, `trig_out_o` or memory contents.
- R10: When `rd_en_i` is high outside capture, `rd_data_o` shows the word at `rd_addr_i` and `rd_valid_o` is high one cycle later. During capture, `rd_valid_o` stays low.
- R11: After reset, armed, triggered, done, `trig_out_o` and `rd_valid_o` are low and `trig_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Start a new capture |
| trig_i | input | 1 | Trigger event |
| qual_i | input | 1 | Per-cycle storage qualifier |
| post_len_i | input | AW+1 | Post-trigger sample count |
| probe_i | input | NGROUPS*GROUP_W | Probe data bus |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | AW | Read address |
| rd_data_o | output | stored width | Read data |
| rd_valid_o | output | 1 | Read data valid |
| armed_o | output | 1 | Waiting for trigger |
| triggered_o | output | 1 | Trigger accepted |
| done_o | output | 1 | Capture complete |
| trig_addr_o | output | AW | Write address at trigger |
| trig_out_o | output | 1 | One-cycle trigger pulse |

## Verification
The assertions check the following on every cycle: trigger-out pulse shape and its source, that the latched trigger address holds outside acceptance, that the address steps by one after each write, that no write happens in the done state or on unqualified cycles, and that reads are blocked during capture. Some behaviour can only be shown by the bench scenarios: that the memory holds the right packed words at the right wrapped addresses, that the post-trigger count is exact (including the zero and clamped cases), and that the unqualified variant stores every cycle.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_POST = 2'd2,
    ST_DONE = 2'd3
  } cap_state_t;

  function automatic bit depth_legal(input int unsigned d);
    return (d >= 512) && (d <= 131072) && ((d & (d - 1)) == 0);
  endfunction

  function automatic int stored_groups_below(input int g, input logic [31:0] pen,
                                             input logic [31:0] sen);
    int n;
    n = 0;
    for (int i = 0; i < g; i++) begin
      if (pen[i] && sen[i]) n++;
    end
    return n;
  endfunction

  function automatic int stored_width(input int ng, input int gw,
                                      input logic [31:0] pen, input logic [31:0] sen);
    return stored_groups_below(ng, pen, sen) * gw;
  endfunction

  function automatic int unsigned post_clamp(input int unsigned req, input int unsigned depth);
    return (req > depth) ? depth : req;
  endfunction

endpackage

// File: rtl/tcap_pack.sv
module tcap_pack #(
  parameter int          NGROUPS  = 4,
  parameter int          GROUP_W  = 8,
  parameter logic [31:0] PROBE_EN = '1,
  parameter logic [31:0] STORE_EN = '1,
  parameter int          SW       = tcap_pkg::stored_width(NGROUPS, GROUP_W, PROBE_EN, STORE_EN)
) (
  input  logic [NGROUPS*GROUP_W-1:0] probe_i,
  output logic [SW-1:0]              word_o
);
  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    if (PROBE_EN[g] && STORE_EN[g]) begin : g_keep
      localparam int OFF = tcap_pkg::stored_groups_below(g, PROBE_EN, STORE_EN) * GROUP_W;
      assign word_o[OFF +: GROUP_W] = probe_i[g*GROUP_W +: GROUP_W];
    end
  end
endmodule

// File: rtl/tcap_ram.sv
module tcap_ram #(
  parameter int unsigned DEPTH = 1024,
  parameter int          W     = 8,
  localparam int         AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/tcap_ctrl.sv
module tcap_ctrl
  import tcap_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int         AW    = $clog2(DEPTH),
  localparam int         PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          trig_i,
  input  logic          qual_ok_i,
  input  logic [PW-1:0] post_len_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          capturing_o,
  output logic          armed_o,
  output logic          triggered_o,
  output logic          done_o,
  output logic [AW-1:0] trig_addr_o,
  output logic          trig_out_o
);
  cap_state_t    state_q;
  logic [AW-1:0] ptr_q;
  logic [PW-1:0] rem_q;
  logic [AW-1:0] taddr_q;
  logic          tout_q;

  // named internal events
  logic          trig_accept;
  logic          zero_post;
  logic [PW-1:0] post_eff;
  logic [PW-1:0] rem_at_trig;

  assign post_eff    = PW'(post_clamp(32'(post_len_i), DEPTH));
  assign zero_post   = (post_eff == '0);
  assign trig_accept = !arm_i && (state_q == ST_PRE) && trig_i;
  assign wr_en_o     = !arm_i && qual_ok_i &&
                       (((state_q == ST_PRE) && !(trig_accept && zero_post)) ||
                        (state_q == ST_POST));
  assign rem_at_trig = post_eff - PW'(wr_en_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      rem_q   <= '0;
      taddr_q <= '0;
      tout_q  <= 1'b0;
    end else begin
      tout_q <= 1'b0;
      if (wr_en_o) ptr_q <= ptr_q + 1'b1;
      if (arm_i) begin
        state_q <= ST_PRE;
        ptr_q   <= '0;
        rem_q   <= '0;
      end else begin
        unique case (state_q)
          ST_PRE: begin
            if (trig_accept) begin
              taddr_q <= ptr_q;
              tout_q  <= 1'b1;
              rem_q   <= zero_post ? '0 : rem_at_trig;
              state_q <= (zero_post || rem_at_trig == '0) ? ST_DONE : ST_POST;
            end
          end
          ST_POST: begin
            if (wr_en_o) begin
              rem_q <= rem_q - 1'b1;
              if (rem_q == PW'(1)) state_q <= ST_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_addr_o   = ptr_q;
  assign capturing_o = (state_q == ST_PRE) || (state_q == ST_POST);
  assign armed_o     = (state_q == ST_PRE);
  assign triggered_o = (state_q == ST_POST) || (state_q == ST_DONE);
  assign done_o      = (state_q == ST_DONE);
  assign trig_addr_o = taddr_q;
  assign trig_out_o  = tout_q;

  AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out_o |=> !trig_out_o); // R8
  AST_TRIG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_accept |=> trig_out_o); // R8
  AST_TADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_accept |=> $stable(trig_addr_o)); // R9
  AST_WRITE_IN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> capturing_o); // R4
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> (wr_addr_o == $past(wr_addr_o) + 1'b1)); // R4
  AST_ARM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (armed_o && !triggered_o && !done_o && wr_addr_o == '0)); // R3
  AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !wr_en_o); // R7
endmodule

// File: rtl/trace_capture.sv
module trace_capture
  import tcap_pkg::*;
#(
  parameter int unsigned DEPTH    = 1024,
  parameter int          NGROUPS  = 4,
  parameter int          GROUP_W  = 8,
  parameter logic [31:0] PROBE_EN = '1,
  parameter logic [31:0] STORE_EN = '1,
  parameter bit          QUAL_EN  = 1'b1,
  localparam int         AW       = $clog2(DEPTH),
  localparam int         PW       = AW + 1,
  localparam int         SW       = stored_width(NGROUPS, GROUP_W, PROBE_EN, STORE_EN)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       arm_i,
  input  logic                       trig_i,
  input  logic                       qual_i,
  input  logic [PW-1:0]              post_len_i,
  input  logic [NGROUPS*GROUP_W-1:0] probe_i,
  input  logic                       rd_en_i,
  input  logic [AW-1:0]              rd_addr_i,
  output logic [SW-1:0]              rd_data_o,
  output logic                       rd_valid_o,
  output logic                       armed_o,
  output logic                       triggered_o,
  output logic                       done_o,
  output logic [AW-1:0]              trig_addr_o,
  output logic                       trig_out_o
);
  if (!depth_legal(DEPTH)) begin : g_bad_depth
    $error("trace_capture: DEPTH must be a power of two in 512..131072");
  end
  if (SW < 1) begin : g_bad_width
    $error("trace_capture: no probe group is enabled for storage");
  end
  if (NGROUPS > 32 || NGROUPS < 1) begin : g_bad_groups
    $error("trace_capture: NGROUPS must be 1..32");
  end

  logic          qual_ok;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic          capturing;
  logic [SW-1:0] word;
  logic          rd_go;
  logic          rd_valid_q;

  assign qual_ok = QUAL_EN ? qual_i : 1'b1;
  assign rd_go   = rd_en_i && !capturing;

  tcap_pack #(
    .NGROUPS(NGROUPS), .GROUP_W(GROUP_W), .PROBE_EN(PROBE_EN), .STORE_EN(STORE_EN), .SW(SW)
  ) u_pack (
    .probe_i(probe_i),
    .word_o (word)
  );

  tcap_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (arm_i),
    .trig_i     (trig_i),
    .qual_ok_i  (qual_ok),
    .post_len_i (post_len_i),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .capturing_o(capturing),
    .armed_o    (armed_o),
    .triggered_o(triggered_o),
    .done_o     (done_o),
    .trig_addr_o(trig_addr_o),
    .trig_out_o (trig_out_o)
  );

  tcap_ram #(.DEPTH(DEPTH), .W(SW)) u_ram (
    .clk    (clk),
    .we_i   (wr_en),
    .waddr_i(wr_addr),
    .wdata_i(word),
    .re_i   (rd_go),
    .raddr_i(rd_addr_i),
    .rdata_o(rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rd_valid_q <= 1'b0;
    else        rd_valid_q <= rd_go;
  end
  assign rd_valid_o = rd_valid_q;

  AST_READ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    capturing |=> !rd_valid_o); // R10
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rd_valid_o); // R10
  AST_QUAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (QUAL_EN && !qual_i) |-> !wr_en); // R5
endmodule

// File: tb/sim_trace_capture.sv
`timescale 1ns/1ps
module sim_trace_capture;
  localparam int D  = 512;
  localparam int AW = 9;
  localparam int PW = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          arm = 1'b0, trig = 1'b0, qual = 1'b0;
  logic [PW-1:0] plen = '0;
  logic [11:0]   probe = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;

  logic [7:0]    rd_data;
  logic          rd_valid, armed, triggered, done, trig_out;
  logic [AW-1:0] trig_addr;
  logic [7:0]    u1_rd_data;
  logic          u1_rd_valid, u1_armed, u1_triggered, u1_done, u1_trig_out;
  logic [AW-1:0] u1_trig_addr;

  trace_capture #(.DEPTH(D), .NGROUPS(3), .GROUP_W(4), .PROBE_EN(32'h7),
                  .STORE_EN(32'h5), .QUAL_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .trig_i(trig), .qual_i(qual),
    .post_len_i(plen), .probe_i(probe), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .armed_o(armed),
    .triggered_o(triggered), .done_o(done), .trig_addr_o(trig_addr), .trig_out_o(trig_out));

  trace_capture #(.DEPTH(D), .NGROUPS(3), .GROUP_W(4), .PROBE_EN(32'h7),
                  .STORE_EN(32'h5), .QUAL_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .trig_i(trig), .qual_i(qual),
    .post_len_i(plen), .probe_i(probe), .rd_en_i(1'b0), .rd_addr_i('0),
    .rd_data_o(u1_rd_data), .rd_valid_o(u1_rd_valid), .armed_o(u1_armed),
    .triggered_o(u1_triggered), .done_o(u1_done), .trig_addr_o(u1_trig_addr),
    .trig_out_o(u1_trig_out));

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model: index 0 = qualified instance, 1 = unqualified instance
  int   mstate [2];
  int   mptr   [2];
  int   mrem   [2];
  int   mtaddr [2];
  bit   mtout  [2];
  logic [7:0] expm [D];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stored word: group 0 in bits 3:0, group 2 in bits 7:4, group 1 dropped (R2)
  function automatic logic [7:0] packw(input logic [11:0] d);
    return {d[11:8], d[3:0]};
  endfunction

  task automatic mstep(input int k, input bit a, input bit t, input bit q0, input logic [11:0] d);
    bit q;
    int pe;
    q = (k == 1) ? 1'b1 : q0;
    pe = (int'(plen) > D) ? D : int'(plen);
    mtout[k] = 0;
    if (a) begin
      mstate[k] = 1; mptr[k] = 0; mrem[k] = 0;
    end else if (mstate[k] == 1) begin
      if (t) begin
        mtaddr[k] = mptr[k]; mtout[k] = 1;
        if (pe == 0) mstate[k] = 3;
        else begin
          if (q) begin
            if (k == 0) expm[mptr[k]] = packw(d);
            mptr[k] = (mptr[k] + 1) % D;
          end
          mrem[k] = pe - int'(q);
          mstate[k] = (mrem[k] == 0) ? 3 : 2;
        end
      end else if (q) begin
        if (k == 0) expm[mptr[k]] = packw(d);
        mptr[k] = (mptr[k] + 1) % D;
      end
    end else if (mstate[k] == 2 && q) begin
      if (k == 0) expm[mptr[k]] = packw(d);
      mptr[k] = (mptr[k] + 1) % D;
      mrem[k]--;
      if (mrem[k] == 0) mstate[k] = 3;
    end
  endtask

  task automatic flags(input string req);
    chk({req, " armed"},      armed,        mstate[0] == 1);
    chk({req, " triggered"},  triggered,    mstate[0] >= 2);
    chk({req, " done"},       done,         mstate[0] == 3);
    chk({req, " trig_out R8"}, trig_out,    mtout[0]);
    chk({req, " trig_addr"},  trig_addr,    mtaddr[0]);
    chk("R5 u1 done",         u1_done,      mstate[1] == 3);
    chk("R5 u1 triggered",    u1_triggered, mstate[1] >= 2);
    chk("R5 u1 trig_addr",    u1_trig_addr, mtaddr[1]);
  endtask

  task automatic cyc(input string req, input bit a, input bit t, input bit q, input logic [11:0] d);
    arm = a; trig = t; qual = q; probe = d;
    mstep(0, a, t, q, d);
    mstep(1, a, t, q, d);
    @(posedge clk); #1;
    arm = 0; trig = 0;
    flags(req);
  endtask

  task automatic rd_all(input string req);
    for (int a = 0; a < D; a++) begin
      rd_en = 1; rd_addr = AW'(a);
      @(posedge clk); #1;
      chk({req, " R10 valid"}, rd_valid, 1'b1);
      chk(req, rd_data, expm[a]);
    end
    rd_en = 0;
    @(posedge clk); #1;
    chk("R10 valid drops", rd_valid, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      mstate[k] = 0; mptr[k] = 0; mrem[k] = 0; mtaddr[k] = 0; mtout[k] = 0;
    end
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    // R11 reset state
    chk("R11 rd_valid", rd_valid, 1'b0);
    flags("R11");

    // A: long pre-trigger wrap, all qualified, post 100 (R1 R4 R6 R7)
    plen = 10'd100;
    cyc("R3 arm", 1, 0, 1, 12'h000);
    for (int i = 0; i < 700; i++) cyc("R4 pre", 0, 0, 1, 12'(i * 37 + 5));
    cyc("R6 trigger", 0, 1, 1, 12'hABC);
    chk("R6 trig_addr wrap R1", trig_addr, 9'd188);
    for (int i = 0; i < 110; i++) cyc("R7 post", 0, 0, 1, 12'(i * 11 + 3));
    chk("R7 done A", done, 1'b1);
    rd_all("R1 R2 R4 memory A");

    // B: qualify every third cycle, trigger on an unqualified cycle (R5)
    plen = 10'd50;
    cyc("R3 arm B", 1, 0, 0, 12'h000);
    for (int i = 0; i < 300; i++) cyc("R5 pre", 0, 0, (i % 3) == 0, 12'(i * 53 + 9));
    cyc("R6 trigger B", 0, 1, 0, 12'h123);
    chk("R6 trig_addr B", trig_addr, 9'd100);
    for (int i = 0; i < 200; i++) cyc("R5 post", 0, 0, (i % 3) == 1, 12'(i * 29 + 1));
    rd_all("R5 memory B");

    // C: triggers after done are ignored (R9)
    for (int i = 0; i < 4; i++) cyc("R9 late trigger", 0, 1, 1, 12'hFFF);
    rd_all("R9 memory unchanged");

    // D: arm+trigger same cycle, read blocked, zero post length (R3 R10 R7)
    plen = 10'd0;
    cyc("R3 arm with trigger", 1, 1, 1, 12'h555);
    rd_en = 1; rd_addr = 9'd3;
    for (int i = 0; i < 5; i++) begin
      cyc("R4 pre D", 0, 0, 1, 12'(i + 16'h700));
      chk("R10 read blocked", rd_valid, 1'b0);
    end
    rd_en = 0;
    cyc("R7 zero post", 0, 1, 1, 12'hEEE);
    chk("R7 zero post done", done, 1'b1);
    chk("R7 zero post addr", trig_addr, 9'd5);
    cyc("R8 pulse ends", 0, 0, 1, 12'h000);
    rd_all("R7 memory D");

    // E: post length above depth is clamped (R7)
    plen = 10'd600;
    cyc("R3 arm E", 1, 0, 1, 12'h000);
    for (int i = 0; i < 10; i++) cyc("R4 pre E", 0, 0, 1, 12'(i * 7));
    cyc("R6 trigger E", 0, 1, 1, 12'h0F0);
    for (int i = 0; i < 520; i++) cyc("R7 clamp", 0, 0, 1, 12'(i * 91 + 4));
    chk("R7 clamp done", done, 1'b1);
    rd_all("R7 memory E");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule